// File: doc/BRIEF.md
# BCD Time-of-Day Clock Core

This core keeps the time of day as six BCD digits: tens and units for hours, minutes and seconds. It runs on one system clock. A one-cycle tick pulse, produced once per second by a prescaler outside the core, advances the seconds while the core is running. The seconds carry into the minutes and the minutes carry into the hours. Hours count from 00 to 23.

One-cycle key pulses control the core. Three adjust keys each step a single field, with no carry into the field above. A clear key sets all digits to zero. A start/stop key toggles between running and stopped. The chime output is high on the even seconds of the first ten seconds of every hour, which gives five beeps, one per second. The chime sounds only while the clock runs.

The digit outputs go to a display encoder and the chime level goes to a buzzer driver. Both of those sit outside the core, as do key debouncing and the one-second prescaler.

Top module: `tod_clock_core`

## Requirements
- R1: After reset the core is stopped, all six digits read 0 (00:00:00) and the chime is low.
- R2: While running, each tick pulse advances the seconds by one in the cycle after the pulse. While stopped, tick pulses leave every digit unchanged.
- R3: Each digit holds a BCD value in 0..9. A units digit at 9 that is incremented returns to 0 and increments its tens digit.
- R4: A tick at seconds 59 sets the seconds to 00 and advances the minutes by one. A carry arriving at minutes 59 sets the minutes to 00 and advances the hours.
- R5: Hours wrap from 23 to 00, so a tick at 23:59:59 gives 00:00:00.
- R6: A pulse on an adjust key (hours, minutes or seconds) increments only that field, wrapping 59 to 00 (or 23 to 00 for hours) without carrying into any other field. It works whether the core is running or stopped.
- R7: A tick-driven step and an adjust pulse for the same field in the same cycle increment that field once. If the tick made the field wrap, the carry into the next field still happens.
- R8: A clear pulse sets all six digits to 0 in the next cycle. It overrides any tick or adjust in the same cycle and leaves the run/stop state unchanged.
- R9: Each start/stop pulse toggles the run state. The first pulse after reset starts counting.
- R10: The chime is high exactly when the core is running, the minutes are 00, the seconds tens digit is 0 and the seconds units digit is even. Across a full hour this gives five high seconds: 00, 02, 04, 06 and 08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| adj_hr_i | input | 1 | Hour adjust key pulse |
| adj_min_i | input | 1 | Minute adjust key pulse |
| adj_sec_i | input | 1 | Second adjust key pulse |
| clear_i | input | 1 | Clear key pulse, zeroes the time |
| runstop_i | input | 1 | Start/stop toggle key pulse |
| hr_tens_o | output | 4 | Hours tens digit (BCD) |
| hr_units_o | output | 4 | Hours units digit (BCD) |
| min_tens_o | output | 4 | Minutes tens digit (BCD) |
| min_units_o | output | 4 | Minutes units digit (BCD) |
| sec_tens_o | output | 4 | Seconds tens digit (BCD) |
| sec_units_o | output | 4 | Seconds units digit (BCD) |
| chime_o | output | 1 | Hourly chime level |

## Verification
The digits are register outputs, so a wrong next-state value in any field shows on the digit ports one cycle after the pulse that caused it. The bench compares all seven outputs against a behavioural model on every clock and catches such a fault in that same cycle. A lost or duplicated carry shows only at the roll-over points: seconds 59, minutes 59 and hour 23. A carry that wrongly leaks out of an adjusted field shows as a step in the next field up. For this reason the stimulus drives each of these boundaries, with and without coincident adjust pulses. A chime fault shows within the first ten seconds of a full hour, or at once if the core is stopped at a full hour.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int unsigned DIGIT_W   = 4;
    localparam int unsigned DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } bcd_pair_t;

    localparam int unsigned SEC_WRAP_TENS  = 5;
    localparam int unsigned SEC_WRAP_UNITS = 9;
    localparam int unsigned MIN_WRAP_TENS  = 5;
    localparam int unsigned MIN_WRAP_UNITS = 9;
    localparam int unsigned HR_WRAP_TENS   = 2;
    localparam int unsigned HR_WRAP_UNITS  = 3;
endpackage

// File: rtl/tod_bcd_field.sv
// Two-digit BCD field with a carrying step input and a non-carrying adjust input.
module tod_bcd_field
    import tod_pkg::*;
#(
    parameter int unsigned WRAP_TENS  = 5,
    parameter int unsigned WRAP_UNITS = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic step_i,
    input  logic adj_i,
    output bcd_t tens_o,
    output bcd_t units_o,
    output logic carry_o
);
    bcd_pair_t val_d, val_q;
    logic      at_wrap, at_units_max, inc;

    always_comb begin
        at_wrap      = (val_q.tens == bcd_t'(WRAP_TENS)) && (val_q.units == bcd_t'(WRAP_UNITS));
        at_units_max = (val_q.units == bcd_t'(DIGIT_MAX));
        inc          = step_i || adj_i;
        val_d        = val_q;
        if (clr_i) begin
            val_d = '0;
        end else if (inc) begin
            if (at_wrap) begin
                val_d = '0;
            end else if (at_units_max) begin
                val_d.units = '0;
                val_d.tens  = val_q.tens + bcd_t'(1);
            end else begin
                val_d.units = val_q.units + bcd_t'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) val_q <= '0;
        else         val_q <= val_d;
    end

    assign tens_o  = val_q.tens;
    assign units_o = val_q.units;
    assign carry_o = step_i && at_wrap && !clr_i;

    assert_digit_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (val_q.units <= bcd_t'(DIGIT_MAX)) && (val_q.tens <= bcd_t'(WRAP_TENS)));
    assert_units_roll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc && !clr_i && at_units_max && !at_wrap) |=> (val_q.units == '0) &&
            (val_q.tens == $past(val_q.tens) + bcd_t'(1)));
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(step_i || adj_i || clr_i) |=> $stable(val_q));
    assert_wrap_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc && at_wrap) |=> (val_q == '0));
    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (val_q == '0));
endmodule

// File: rtl/tod_run_ctrl.sv
// Run/stop toggle flop.
module tod_run_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic toggle_i,
    output logic run_o
);
    logic run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (toggle_i) run_d = !run_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= 1'b0;
        else         run_q <= run_d;
    end

    assign run_o = run_q;

    assert_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        toggle_i |=> (run_q != $past(run_q)));
    assert_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !toggle_i |=> $stable(run_q));
endmodule

// File: rtl/tod_chime.sv
// Hourly chime decode from the registered time.
module tod_chime
    import tod_pkg::*;
(
    input  logic run_i,
    input  bcd_t min_tens_i,
    input  bcd_t min_units_i,
    input  bcd_t sec_tens_i,
    input  bcd_t sec_units_i,
    output logic chime_o
);
    logic full_hour, even_sec;

    always_comb begin
        full_hour = (min_tens_i == '0) && (min_units_i == '0) && (sec_tens_i == '0);
        even_sec  = !sec_units_i[0];
        chime_o   = run_i && full_hour && even_sec;
    end
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
    import tod_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       adj_hr_i,
    input  logic       adj_min_i,
    input  logic       adj_sec_i,
    input  logic       clear_i,
    input  logic       runstop_i,
    output logic [3:0] hr_tens_o,
    output logic [3:0] hr_units_o,
    output logic [3:0] min_tens_o,
    output logic [3:0] min_units_o,
    output logic [3:0] sec_tens_o,
    output logic [3:0] sec_units_o,
    output logic       chime_o
);
    logic run, sec_step, sec_carry, min_carry, hr_carry;
    bcd_t s_t, s_u, m_t, m_u, h_t, h_u;

    assign sec_step = tick_i && run;

    tod_run_ctrl u_run (
        .clk_i(clk_i), .rst_ni(rst_ni), .toggle_i(runstop_i), .run_o(run)
    );

    tod_bcd_field #(.WRAP_TENS(SEC_WRAP_TENS), .WRAP_UNITS(SEC_WRAP_UNITS)) u_sec (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .step_i(sec_step),
        .adj_i(adj_sec_i), .tens_o(s_t), .units_o(s_u), .carry_o(sec_carry)
    );

    tod_bcd_field #(.WRAP_TENS(MIN_WRAP_TENS), .WRAP_UNITS(MIN_WRAP_UNITS)) u_min (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .step_i(sec_carry),
        .adj_i(adj_min_i), .tens_o(m_t), .units_o(m_u), .carry_o(min_carry)
    );

    tod_bcd_field #(.WRAP_TENS(HR_WRAP_TENS), .WRAP_UNITS(HR_WRAP_UNITS)) u_hr (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .step_i(min_carry),
        .adj_i(adj_hr_i), .tens_o(h_t), .units_o(h_u), .carry_o(hr_carry)
    );

    tod_chime u_chime (
        .run_i(run), .min_tens_i(m_t), .min_units_i(m_u),
        .sec_tens_i(s_t), .sec_units_i(s_u), .chime_o(chime_o)
    );

    assign hr_tens_o   = h_t;
    assign hr_units_o  = h_u;
    assign min_tens_o  = m_t;
    assign min_units_o = m_u;
    assign sec_tens_o  = s_t;
    assign sec_units_o = s_u;

    assert_stopped_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !run && !adj_sec_i && !clear_i) |=> ($stable(s_t) && $stable(s_u)));
    assert_no_carry_sec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adj_sec_i && !tick_i && !adj_min_i && !clear_i) |=> ($stable(m_t) && $stable(m_u)));
    assert_no_carry_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sec_carry && !adj_hr_i && !clear_i) |=> ($stable(h_t) && $stable(h_u)));
    assert_sec_rollover_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sec_carry && !adj_min_i && !clear_i && !(m_t == 4'd5 && m_u == 4'd9))
            |=> ({m_t, m_u} != $past({m_t, m_u})));
    assert_hr_no_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hr_carry || (h_t == 4'd2 && h_u == 4'd3));
    assert_chime_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chime_o |-> run);
endmodule

// File: tb/tod_clock_core_tb_top.sv
module tod_clock_core_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, adj_h = 0, adj_m = 0, adj_s = 0, clr = 0, rs = 0;
    logic [3:0] ht, hu, mt, mu, st, su;
    logic chime;

    int checks = 0;
    int fails  = 0;
    int m_h = 0, m_m = 0, m_s = 0;
    bit m_run = 0;
    int beeps;

    always #4 clk = ~clk;

    tod_clock_core dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .adj_hr_i(adj_h),
        .adj_min_i(adj_m), .adj_sec_i(adj_s), .clear_i(clr), .runstop_i(rs),
        .hr_tens_o(ht), .hr_units_o(hu), .min_tens_o(mt), .min_units_o(mu),
        .sec_tens_o(st), .sec_units_o(su), .chime_o(chime)
    );

    function automatic bit exp_chime();
        return m_run && m_m == 0 && m_s < 10 && (m_s % 2) == 0;
    endfunction

    task automatic compare(string tag);
        int got_h, got_m, got_s;
        got_h = ht * 10 + hu;
        got_m = mt * 10 + mu;
        got_s = st * 10 + su;
        checks++;
        if (ht > 9 || hu > 9 || mt > 9 || mu > 9 || st > 9 || su > 9 ||
            got_h != m_h || got_m != m_m || got_s != m_s || chime != exp_chime()) begin
            fails++;
            $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d chime=%0b, expected %02d:%02d:%02d chime=%0b",
                     tag, ht, hu, mt, mu, st, su, chime, m_h, m_m, m_s, exp_chime());
        end
    endtask

    // Drive one cycle of inputs (called at a falling edge), update the model, compare.
    task automatic cyc(bit t, bit ah, bit am, bit as_, bit c, bit r, string tag);
        bit sc, mc;
        tick = t; adj_h = ah; adj_m = am; adj_s = as_; clr = c; rs = r;
        @(posedge clk);
        if (c) begin
            m_h = 0; m_m = 0; m_s = 0;
        end else begin
            sc = t && m_run && m_s == 59;
            mc = sc && m_m == 59;
            if ((t && m_run) || as_) m_s = (m_s + 1) % 60;
            if (sc || am) m_m = (m_m + 1) % 60;
            if (mc || ah) m_h = (m_h + 1) % 24;
        end
        if (r) m_run = !m_run;
        @(negedge clk);
        tick = 0; adj_h = 0; adj_m = 0; adj_s = 0; clr = 0; rs = 0;
        compare(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic set_time(int h, int m, int s);
        while (m_h != h) cyc(0, 1, 0, 0, 0, 0, "R6");
        while (m_m != m) cyc(0, 0, 1, 0, 0, 0, "R6");
        while (m_s != s) cyc(0, 0, 0, 1, 0, 0, "R6");
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
        // R2: ticks while stopped are ignored
        for (int i = 0; i < 4; i++) begin cyc(1, 0, 0, 0, 0, 0, "R2 stopped"); idle(2, "R2"); end
        // R9: start, R2/R3: run 25 seconds, units roll into tens
        cyc(0, 0, 0, 0, 0, 1, "R9 start");
        for (int i = 0; i < 25; i++) begin cyc(1, 0, 0, 0, 0, 0, "R3 count"); idle(1, "R2"); end
        // R4: seconds 59 -> minutes advance
        set_time(0, 5, 59);
        cyc(1, 0, 0, 0, 0, 0, "R4 sec carry");
        // R6: adjust seconds at 59 never carries
        set_time(0, 5, 59);
        cyc(0, 0, 0, 1, 0, 0, "R6 sec adj wrap");
        // R7: tick and adjust together, carry kept
        set_time(0, 7, 58);
        cyc(1, 0, 0, 1, 0, 0, "R7 coincide");
        cyc(1, 0, 0, 1, 0, 0, "R7 coincide wrap");
        // R6: minutes adjust at 59 does not carry into hours
        set_time(3, 59, 10);
        cyc(0, 0, 1, 0, 0, 0, "R6 min adj wrap");
        // R4: minutes 59 carry into hours
        set_time(4, 59, 59);
        cyc(1, 0, 0, 0, 0, 0, "R4 min carry");
        // R5 + R10: 23:59:59 rolls to 00:00:00 and the chime beeps five times
        set_time(23, 59, 55);
        beeps = 0;
        for (int i = 0; i < 14; i++) begin
            cyc(1, 0, 0, 0, 0, 0, "R5 R10 rollover");
            if (chime) beeps++;
        end
        checks++;
        if (beeps != 5) begin
            fails++;
            $display("FAIL R10: got %0d beeps, expected 5", beeps);
        end
        // R6: hour adjust at 23 wraps, no effect elsewhere
        set_time(23, 30, 30);
        cyc(0, 1, 0, 0, 0, 0, "R6 hr adj wrap");
        // R8: clear beats tick and adjusts, run kept
        cyc(1, 1, 1, 1, 1, 0, "R8 clear priority");
        cyc(1, 0, 0, 0, 0, 0, "R8 still running");
        // R9 stop, R6 adjust while stopped, R10 chime off while stopped
        set_time(0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1, "R9 stop");
        cyc(0, 0, 0, 1, 0, 0, "R10 stopped no chime");
        cyc(1, 0, 0, 0, 0, 0, "R2 stopped tick");
        cyc(0, 1, 1, 1, 0, 0, "R6 adjust stopped");
        cyc(0, 0, 0, 0, 1, 1, "R8 R9 clear and start");
        cyc(1, 0, 0, 0, 0, 0, "R9 running again");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule